// File: doc/BRIEF.md
# Bus-Driving Arithmetic-Logic Unit with Fully Decoded Function Select

This block is the arithmetic-logic unit of a small teaching computer. It takes two 8-bit operand registers, called B and C, and a 4-bit function code. The code is expanded into sixteen one-hot select lines. Each line enables a single operation lane onto the shared data bus, so the lanes behave like tri-state drivers. The unit also reports a zero flag, a sign flag and a carry/borrow flag for whatever value it places on the bus.

Function code 0 means the unit is idle. A sequencer that wants the ALU off the bus therefore only has to stop driving the decoder. The undefined codes 10 to 15 behave the same way. The whole unit is combinational: there is no clock and no stored state, and every output follows its inputs directly. Bit 7 of a result is read as the sign and bits 6..0 as the magnitude. An arithmetic result that spills into bit 7 is not trapped, so the sign flag simply mirrors bit 7.

Top module: `bus_alu`

## Requirements
- R1: With function code 0, bus_drive_o is 0 and result_o, zero_o, sign_o and carry_o are all 0, whatever the operand values.
- R2: Codes 10 through 15 act exactly like code 0: no drive, result 0 and all flags 0.
- R3: Code 1 (add) puts (B + C) mod 256 on result_o, and carry_o equals bit 8 of the 9-bit sum.
- R4: Code 2 (subtract) puts (B − C) mod 256 on result_o, and carry_o is 1 exactly when B < C as unsigned numbers (borrow).
- R5: Codes 3, 4 and 5 put B AND C, B OR C and B XOR C on result_o, in that order.
- R6: Code 6 puts the bitwise inverse of C on result_o with B ignored, and code 7 puts NOT(B AND C) on result_o.
- R7: Code 8 puts B shifted right by one place on result_o, filling bit 7 with 0, with C ignored.
- R8: Code 9 drives the constant 0x00 onto the bus, so bus_drive_o is 1 and zero_o is 1.
- R9: bus_drive_o is 1 for codes 1 through 9 and 0 for every other code.
- R10: While the bus is driven, zero_o is 1 exactly when result_o is 0x00.
- R11: While the bus is driven, sign_o equals result_o bit 7. Signed overflow is not flagged: 0x7F + 0x01 gives 0x80 with sign_o 1 and carry_o 0.
- R12: carry_o is 0 for every code other than 1 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn_code_i | input | 4 | Function code; 0 and 10–15 mean idle |
| op_b_i | input | 8 | Operand register B |
| op_c_i | input | 8 | Operand register C |
| result_o | output | 8 | Selected lane value; 0 when not driving |
| bus_drive_o | output | 1 | High while a valid operation owns the bus |
| zero_o | output | 1 | Result is all zeros (only while driving) |
| sign_o | output | 1 | Bit 7 of the result (only while driving) |
| carry_o | output | 1 | Carry of add, borrow of subtract |

## Verification
Every output is combinational, so every result is due in the same time step as its stimulus and zero clock cycles after it. The bench changes the code and the operands on a falling edge of its clock. It samples two nanoseconds later, well before the next rising edge, so it never reads a value that is still settling or that depends on edge ordering. Table vectors and a reference-model sweep over corner and pseudo-random operands both use this drive-then-wait pattern.

// File: rtl/bus_alu_pkg.sv
package bus_alu_pkg;

    localparam int FN_W    = 4;
    localparam int NUM_SEL = 2 ** FN_W;

    typedef enum logic [FN_W-1:0] {
        FN_IDLE = 4'd0,
        FN_ADD  = 4'd1,
        FN_SUB  = 4'd2,
        FN_AND  = 4'd3,
        FN_OR   = 4'd4,
        FN_XOR  = 4'd5,
        FN_NOTC = 4'd6,
        FN_NAND = 4'd7,
        FN_SHR  = 4'd8,
        FN_ZERO = 4'd9
    } fn_e;

    localparam int FN_FIRST = int'(FN_ADD);
    localparam int FN_LAST  = int'(FN_ZERO);

    typedef struct packed {
        logic drive;
        logic zero;
        logic sign;
        logic carry;
    } alu_flags_t;

    function automatic logic fn_is_arith(input logic [FN_W-1:0] code);
        return (code == FN_ADD) || (code == FN_SUB);
    endfunction

    function automatic logic fn_in_range(input logic [FN_W-1:0] code);
        return (int'(code) >= FN_FIRST) && (int'(code) <= FN_LAST);
    endfunction

endpackage

// File: rtl/alu_fn_decode.sv
module alu_fn_decode
    import bus_alu_pkg::*;
(
    input  logic [FN_W-1:0]    code_i,
    output logic [NUM_SEL-1:0] sel_o
);

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_line
        assign sel_o[i] = (code_i == FN_W'(i));
    end

endmodule

// File: rtl/alu_lanes.sv
module alu_lanes
    import bus_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]               b_i,
    input  logic [DATA_W-1:0]               c_i,
    output logic [NUM_SEL-1:0][DATA_W-1:0]  lane_o,
    output logic                            add_carry_o,
    output logic                            sub_borrow_o
);

    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] sum_ext;
    logic [EXT_W-1:0] diff_ext;

    assign sum_ext      = {1'b0, b_i} + {1'b0, c_i};
    assign diff_ext     = {1'b0, b_i} - {1'b0, c_i};
    assign add_carry_o  = sum_ext[DATA_W];
    assign sub_borrow_o = diff_ext[DATA_W];

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_lane
        if (i == int'(FN_ADD)) begin : g_add
            assign lane_o[i] = sum_ext[DATA_W-1:0];
        end else if (i == int'(FN_SUB)) begin : g_sub
            assign lane_o[i] = diff_ext[DATA_W-1:0];
        end else if (i == int'(FN_AND)) begin : g_and
            assign lane_o[i] = b_i & c_i;
        end else if (i == int'(FN_OR)) begin : g_or
            assign lane_o[i] = b_i | c_i;
        end else if (i == int'(FN_XOR)) begin : g_xor
            assign lane_o[i] = b_i ^ c_i;
        end else if (i == int'(FN_NOTC)) begin : g_notc
            assign lane_o[i] = ~c_i;
        end else if (i == int'(FN_NAND)) begin : g_nand
            assign lane_o[i] = ~(b_i & c_i);
        end else if (i == int'(FN_SHR)) begin : g_shr
            assign lane_o[i] = {1'b0, b_i[DATA_W-1:1]};
        end else begin : g_const
            assign lane_o[i] = '0;
        end
    end

endmodule

// File: rtl/alu_bus_mux.sv
module alu_bus_mux
    import bus_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [NUM_SEL-1:0]              sel_i,
    input  logic [NUM_SEL-1:0][DATA_W-1:0]  lane_i,
    input  logic                            add_carry_i,
    input  logic                            sub_borrow_i,
    output logic [DATA_W-1:0]               bus_o,
    output logic                            drive_o,
    output logic                            carry_o
);

    logic [NUM_SEL-1:0][DATA_W-1:0] gated;
    logic [FN_LAST:FN_FIRST]         owner;

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_gate
        if (i >= FN_FIRST && i <= FN_LAST) begin : g_live
            assign gated[i] = lane_i[i] & {DATA_W{sel_i[i]}};
            assign owner[i] = sel_i[i];
        end else begin : g_dead
            assign gated[i] = '0;
        end
    end

    always_comb begin
        bus_o = '0;
        for (int i = 0; i < NUM_SEL; i++) begin
            bus_o = bus_o | gated[i];
        end
    end

    assign drive_o = |owner;
    assign carry_o = (sel_i[FN_ADD] & add_carry_i) | (sel_i[FN_SUB] & sub_borrow_i);

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import bus_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] bus_i,
    input  logic              drive_i,
    input  logic              carry_i,
    output alu_flags_t        flags_o
);

    localparam int SIGN_BIT = DATA_W - 1;

    always_comb begin
        flags_o.drive = drive_i;
        flags_o.zero  = drive_i & ~(|bus_i);
        flags_o.sign  = drive_i & bus_i[SIGN_BIT];
        flags_o.carry = drive_i & carry_i;
    end

endmodule

// File: rtl/bus_alu.sv
module bus_alu
    import bus_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [FN_W-1:0]   fn_code_i,
    input  logic [DATA_W-1:0] op_b_i,
    input  logic [DATA_W-1:0] op_c_i,
    output logic [DATA_W-1:0] result_o,
    output logic              bus_drive_o,
    output logic              zero_o,
    output logic              sign_o,
    output logic              carry_o
);

    localparam int SIGN_BIT = DATA_W - 1;

    logic [NUM_SEL-1:0]             sel;
    logic [NUM_SEL-1:0][DATA_W-1:0] lane;
    logic                           add_carry;
    logic                           sub_borrow;
    logic [DATA_W-1:0]              bus_val;
    logic                           drive;
    logic                           carry_raw;
    alu_flags_t                     flags;

    alu_fn_decode u_decode (
        .code_i (fn_code_i),
        .sel_o  (sel)
    );

    alu_lanes #(.DATA_W(DATA_W)) u_lanes (
        .b_i          (op_b_i),
        .c_i          (op_c_i),
        .lane_o       (lane),
        .add_carry_o  (add_carry),
        .sub_borrow_o (sub_borrow)
    );

    alu_bus_mux #(.DATA_W(DATA_W)) u_mux (
        .sel_i        (sel),
        .lane_i       (lane),
        .add_carry_i  (add_carry),
        .sub_borrow_i (sub_borrow),
        .bus_o        (bus_val),
        .drive_o      (drive),
        .carry_o      (carry_raw)
    );

    alu_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .bus_i   (bus_val),
        .drive_i (drive),
        .carry_i (carry_raw),
        .flags_o (flags)
    );

    assign result_o    = bus_val;
    assign bus_drive_o = flags.drive;
    assign zero_o      = flags.zero;
    assign sign_o      = flags.sign;
    assign carry_o     = flags.carry;

    // Checks between the function code and the outputs of separate sub-blocks
    always_comb begin
        if (fn_code_i == FN_IDLE) begin
            assert_idle_quiet_R1: assert (!bus_drive_o && result_o == '0)
                else $error("idle code drove the bus");
        end
        if (!fn_in_range(fn_code_i)) begin
            assert_undriven_flags_R2: assert (!zero_o && !sign_o && !carry_o && result_o == '0)
                else $error("undriven bus has flags or data");
        end
        if (fn_in_range(fn_code_i)) begin
            assert_valid_drives_R9: assert (bus_drive_o)
                else $error("valid code did not drive");
        end
        if (bus_drive_o) begin
            assert_zero_matches_R10: assert (zero_o == (result_o == '0))
                else $error("zero flag mismatch");
            assert_sign_matches_R11: assert (sign_o == result_o[SIGN_BIT])
                else $error("sign flag mismatch");
        end
        if (!fn_is_arith(fn_code_i)) begin
            assert_no_carry_R12: assert (!carry_o)
                else $error("carry outside add/sub");
        end
        if (fn_code_i == FN_ZERO) begin
            assert_const_zero_R8: assert (bus_drive_o && zero_o && result_o == '0)
                else $error("constant lane wrong");
        end
    end

endmodule

// File: tb/sim_bus_alu.sv
`timescale 1ns/1ps
module sim_bus_alu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] code;
    logic [7:0] b, c;
    logic [7:0] res;
    logic       drv, zf, sf, cf;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    bus_alu u0 (
        .fn_code_i   (code),
        .op_b_i      (b),
        .op_c_i      (c),
        .result_o    (res),
        .bus_drive_o (drv),
        .zero_o      (zf),
        .sign_o      (sf),
        .carry_o     (cf)
    );

    // {code, b, c, result, drive, zero, sign, carry}
    localparam logic [31:0] VEC [14] = '{
        {4'd1,  8'h7F, 8'h01, 8'h80, 4'b1010},
        {4'd1,  8'hFF, 8'h01, 8'h00, 4'b1101},
        {4'd2,  8'h05, 8'h03, 8'h02, 4'b1000},
        {4'd2,  8'h00, 8'h01, 8'hFF, 4'b1011},
        {4'd3,  8'hF0, 8'h3C, 8'h30, 4'b1000},
        {4'd4,  8'hF0, 8'h0F, 8'hFF, 4'b1010},
        {4'd5,  8'hAA, 8'hAA, 8'h00, 4'b1100},
        {4'd6,  8'h12, 8'h0F, 8'hF0, 4'b1010},
        {4'd7,  8'hFF, 8'hFF, 8'h00, 4'b1100},
        {4'd8,  8'h81, 8'h55, 8'h40, 4'b1000},
        {4'd9,  8'h5A, 8'hA5, 8'h00, 4'b1100},
        {4'd0,  8'hFF, 8'hFF, 8'h00, 4'b0000},
        {4'd15, 8'h80, 8'h80, 8'h00, 4'b0000},
        {4'd10, 8'h01, 8'h01, 8'h00, 4'b0000}
    };

    function automatic string req_of(input logic [3:0] k);
        case (k)
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3, 4'd4, 4'd5: return "R5";
            4'd6, 4'd7: return "R6";
            4'd8: return "R7";
            4'd9: return "R8";
            4'd0: return "R1";
            default: return "R2";
        endcase
    endfunction

    // Independent reference: {result, drive, zero, sign, carry}
    function automatic logic [11:0] model(input logic [3:0] k, input logic [7:0] x, input logic [7:0] y);
        logic [8:0] t;
        logic [7:0] r;
        logic       cy;
        logic       on;
        r = 8'h00; cy = 1'b0; on = 1'b1;
        case (k)
            4'd1: begin t = x + y; r = t[7:0]; cy = t[8]; end
            4'd2: begin r = x - y; cy = (x < y); end
            4'd3: r = x & y;
            4'd4: r = x | y;
            4'd5: r = x ^ y;
            4'd6: r = ~y;
            4'd7: r = ~(x & y);
            4'd8: r = x / 2;
            4'd9: r = 8'h00;
            default: on = 1'b0;
        endcase
        if (!on) return 12'h000;
        return {r, 1'b1, (r == 8'h00), r[7], cy};
    endfunction

    task automatic check(input string tag, input logic [11:0] exp);
        logic [11:0] act;
        act = {res, drv, zf, sf, cf};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s code=%0d b=%h c=%h actual=%h expected=%h", tag, code, b, c, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] k, input logic [7:0] x, input logic [7:0] y);
        @(negedge clk);
        code = k; b = x; c = y;
        #2;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [7:0] CORNER [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};

    initial begin : stim
        logic [31:0] seed;
        seed = 32'h1234_5678;
        code = 4'd0; b = 8'hC3; c = 8'h3C;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset state", 12'h000);
        rst = 1'b0;

        for (int i = 0; i < 14; i++) begin
            apply(VEC[i][31:28], VEC[i][27:20], VEC[i][19:12]);
            check(req_of(VEC[i][31:28]), VEC[i][11:0]);
        end

        // R11: signed overflow not trapped
        apply(4'd1, 8'h7F, 8'h01);
        check("R11 overflow", {8'h80, 4'b1010});
        // R9: drive per code
        for (int k = 0; k < 16; k++) begin
            apply(4'(k), 8'h33, 8'h11);
            total++;
            if (drv !== (k >= 1 && k <= 9)) begin
                bad++;
                $display("FAIL R9 code=%0d actual=%b expected=%b", k, drv, (k >= 1 && k <= 9));
            end
        end
        // R6 / R7: ignored operand has no effect
        apply(4'd6, 8'h00, 8'h5A);
        check("R6 B ignored", model(4'd6, 8'h00, 8'h5A));
        apply(4'd6, 8'hFF, 8'h5A);
        check("R6 B ignored", model(4'd6, 8'h00, 8'h5A));
        apply(4'd8, 8'hFE, 8'h00);
        check("R7 C ignored", {8'h7F, 4'b1000});
        apply(4'd8, 8'hFE, 8'hFF);
        check("R7 C ignored", {8'h7F, 4'b1000});

        // Sweep: every code over corner pairs and pseudo-random operands (R10 R12)
        for (int k = 0; k < 16; k++) begin
            for (int p = 0; p < 4; p++) begin
                for (int q = 0; q < 4; q++) begin
                    apply(4'(k), CORNER[p], CORNER[q]);
                    check({req_of(4'(k)), " R10 R12 corner"}, model(4'(k), CORNER[p], CORNER[q]));
                end
            end
            for (int n = 0; n < 24; n++) begin
                seed = seed * 32'd1103515245 + 32'd12345;
                apply(4'(k), seed[23:16], seed[15:8]);
                check({req_of(4'(k)), " R10 R12 random"}, model(4'(k), seed[23:16], seed[15:8]));
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule